// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block is a free-running countdown timer that raises a periodic interrupt. A 16-bit count steps down by one on every prescaled tick. The tick comes from an 8-bit prescaler whose register holds n-1, so a tick occurs once every n clock cycles. When a tick finds the count at zero, the count reloads from a separate 16-bit period register and the interrupt output pulses.

Software writes the count, the period and the scale through three independent write strobes, and a level enable starts and stops the timer. The current count is visible on an output port. With period P and scale S, interrupts repeat every (P+1)*(S+1) clock cycles.

Top module: `tick_timer`

## Requirements
- R1: While `rst_n` is low, the count, period, scale and prescaler are cleared. After reset, `count` reads 0 and `irq` is 0.
- R2: While enabled and with no count write, a prescaled tick occurs every S+1 clock cycles, where S is the value of the scale register. S=0 gives a tick on every cycle and S=255 gives a tick every 256 cycles.
- R3: A tick that finds a non-zero count lowers the count by exactly one.
- R4: A tick that finds the count at zero loads the count from the period register. `irq` is high for exactly the one cycle in which `count` first shows the reloaded value. With period P, interrupts are (P+1)*(S+1) cycles apart.
- R5: With a period of 0, every tick produces an interrupt, and `count` stays at 0.
- R6: While `enable` is low, no tick occurs, `count` holds and `irq` stays 0. The prescaler keeps its remaining interval, so counting resumes from where it stopped.
- R7: A count write loads `cnt_wdata` at the next clock edge and restarts the prescale interval. The first decrement after the write comes S+1 cycles after the write edge.
- R8: A count write at the same edge as a tick takes priority. The written value is loaded, no decrement or reload happens, and `irq` stays 0 for that edge.
- R9: A period write is used by the next reload that comes after the write edge. A scale write takes effect when the prescaler next restarts its interval. That restart happens when the current interval ends or on a count write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Timer run enable (level) |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | Count write value |
| per_wr | input | 1 | Period write strobe |
| per_wdata | input | 16 | Period write value |
| scl_wr | input | 1 | Scale write strobe |
| scl_wdata | input | 8 | Scale write value (n-1) |
| count | output | 16 | Current count value |
| irq | output | 1 | One-cycle interrupt pulse on reload |

## Verification
Two functions can fall on the same edge: a software count write, and a prescaled tick that finds the count at zero and would reload it. The bench provokes this with a scale of 0, writing count 0 and then 7 on back-to-back edges, so the second write meets a zero-count tick. The collision is judged correct when `count` shows 7 with `irq` low, followed by a normal decrement to 6. A second overlap is also tested: a scale write on a tick edge, where the bench checks that the old interval finishes before the new one applies.

// File: rtl/tick_timer_pkg.sv
// Package: shared widths and the per-edge action of the count register.
// Assumes: consumed by every module of the tick_timer block.
package tick_timer_pkg;

    localparam int DEF_CNT_W = 16;
    localparam int DEF_SCL_W = 8;

    // What the count register does at the coming edge
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOAD   = 2'd1,
        ACT_DEC    = 2'd2,
        ACT_RELOAD = 2'd3
    } cnt_act_e;

endpackage

// File: rtl/tick_timer_regs.sv
// Module: holds the period and scale registers written by software.
// Assumes: write strobes are single-cycle qualified; values are used as-is.
module tick_timer_regs #(
    parameter int CNT_W = tick_timer_pkg::DEF_CNT_W,
    parameter int SCL_W = tick_timer_pkg::DEF_SCL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             scl_wr,
    input  logic [SCL_W-1:0] scl_wdata,
    output logic [CNT_W-1:0] period,
    output logic [SCL_W-1:0] scale
);

    // Period register: captured on its write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
        end else if (per_wr) begin
            period <= per_wdata;
        end
    end

    // Scale register: captured on its write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scale <= '0;
        end else if (scl_wr) begin
            scale <= scl_wdata;
        end
    end

endmodule

// File: rtl/tick_timer_prescaler.sv
// Module: divides the clock by scale+1 and emits a one-cycle tick.
// Assumes: restart has priority over counting and reloads the full interval;
//          the scale value is sampled only when the interval restarts.
module tick_timer_prescaler #(
    parameter int SCL_W = tick_timer_pkg::DEF_SCL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic [SCL_W-1:0] scale,
    output logic             tick
);

    logic [SCL_W-1:0] left_q;
    logic             expired;

    // Interval ends when the remaining-cycle count sits at zero
    always_comb begin
        expired = (left_q == '0);
        tick    = enable && !restart && expired;
    end

    // Remaining-cycle counter: restart, reload on expiry, or step down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (restart) begin
            left_q <= scale;
        end else if (enable) begin
            if (expired) begin
                left_q <= scale;
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/tick_timer_counter.sv
// Module: 16-bit down counter with reload from period and interrupt pulse.
// Assumes: a write beats a tick; reload happens on a tick that sees zero.
module tick_timer_counter
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             irq
);

    cnt_act_e act;

    // Choose this edge's action in priority order
    always_comb begin
        if (wr) begin
            act = ACT_LOAD;
        end else if (tick) begin
            act = (count == '0) ? ACT_RELOAD : ACT_DEC;
        end else begin
            act = ACT_HOLD;
        end
    end

    // Count register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case (act)
                ACT_LOAD:   count <= wdata;
                ACT_RELOAD: count <= period;
                ACT_DEC:    count <= count - 1'b1;
                default:    count <= count;
            endcase
        end
    end

    // Interrupt pulse aligned with the reloaded count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= (act == ACT_RELOAD);
        end
    end

endmodule

// File: rtl/tick_timer.sv
// Module: top of the prescaled periodic interval timer.
// Assumes: software drives single-cycle write strobes; enable is a level.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int SCL_W = DEF_SCL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             scl_wr,
    input  logic [SCL_W-1:0] scl_wdata,
    output logic [CNT_W-1:0] count,
    output logic             irq
);

    logic [CNT_W-1:0] period_w;
    logic [SCL_W-1:0] scale_w;
    logic             tick_w;

    tick_timer_regs #(.CNT_W(CNT_W), .SCL_W(SCL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_wr    (per_wr),
        .per_wdata (per_wdata),
        .scl_wr    (scl_wr),
        .scl_wdata (scl_wdata),
        .period    (period_w),
        .scale     (scale_w)
    );

    tick_timer_prescaler #(.SCL_W(SCL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .restart (cnt_wr),
        .scale   (scale_w),
        .tick    (tick_w)
    );

    tick_timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_w),
        .wr     (cnt_wr),
        .wdata  (cnt_wdata),
        .period (period_w),
        .count  (count),
        .irq    (irq)
    );

endmodule

// File: rtl/tick_timer_chk.sv
// Module: assertion checker for tick_timer, attached by bind below.
// Assumes: sees the top's ports and its internal prescaled tick.
module tick_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic [CNT_W-1:0] count,
    input logic             irq,
    input logic             tick
);

    // R1: reset clears count and interrupt
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !irq));

    // R3: a tick on a non-zero count steps it down by one
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && count != '0) |=> (count == $past(count) - 1'b1));

    // R4: an interrupt only follows a tick that found zero
    a_r4_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(tick) && $past(count) == '0 && !$past(cnt_wr)));

    // R6: disabled timer produces no tick
    a_r6_no_tick_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !tick);

    // R6: disabled timer without writes holds its count
    a_r6_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !cnt_wr) |=> ($stable(count) && !irq));

    // R8: a count write is loaded and suppresses the interrupt
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(cnt_wdata) && !irq));

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .count     (count),
    .irq       (irq),
    .tick      (tick_w)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic        per_wr = 1'b0;
    logic [15:0] per_wdata = '0;
    logic        scl_wr = 1'b0;
    logic [7:0]  scl_wdata = '0;
    logic [15:0] count;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .per_wr(per_wr), .per_wdata(per_wdata),
        .scl_wr(scl_wr), .scl_wdata(scl_wdata),
        .count(count), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Caller stands at a negedge; leaves the write applied at the next edge
    task automatic wr_count(input int v);
        cnt_wr = 1'b1;
        cnt_wdata = 16'(v);
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic config_run(input int s, input int p, input int cycles);
        int len;
        int ticks;
        string tg;
        len = (p + 1) * (s + 1);
        tg = (p == 0) ? "R5" : "R4";
        @(negedge clk);
        enable = 1'b0;
        scl_wr = 1'b1; scl_wdata = 8'(s);
        per_wr = 1'b1; per_wdata = 16'(p);
        @(negedge clk);
        scl_wr = 1'b0; per_wr = 1'b0;
        enable = 1'b1;
        wr_count(p);
        chk("R7 count after write", int'(count), p);
        for (int i = 1; i <= cycles; i++) begin
            @(negedge clk);
            ticks = i / (s + 1);
            chk(tg, int'(irq), (i % len == 0) ? 1 : 0);
            chk("R2/R3 count", int'(count), (p - (ticks % (p + 1))));
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 count", int'(count), 0);
        chk("R1 irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count after release", int'(count), 0);

        // Sweep small scales and periods
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 6; p++) begin
                config_run(s, p, 2 * (p + 1) * (s + 1) + 3);
            end
        end
        // R2 largest scale
        config_run(255, 1, 1030);

        // R6: disable holds count and prescaler
        config_run(2, 3, 4);          // count now 2, one prescale cycle used
        enable = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R6 hold count", int'(count), 2);
            chk("R6 no irq", int'(irq), 0);
        end
        enable = 1'b1;
        @(negedge clk);
        chk("R6 resume first", int'(count), 2);
        @(negedge clk);
        chk("R6 resume second", int'(count), 1);

        // R8: count write meets a zero-count tick (scale 0)
        config_run(0, 4, 0);
        wr_count(0);
        wr_count(7);
        chk("R8 write wins count", int'(count), 7);
        chk("R8 write wins irq", int'(irq), 0);
        @(negedge clk);
        chk("R8 next decrement", int'(count), 6);

        // R9: period write used at next reload
        wr_count(1);
        per_wr = 1'b1; per_wdata = 16'd9;
        @(negedge clk);
        per_wr = 1'b0;
        chk("R9 count before reload", int'(count), 0);
        @(negedge clk);
        chk("R9 reload new period", int'(count), 9);
        chk("R9 reload irq", int'(irq), 1);

        // R9: scale write applies after the current interval
        scl_wr = 1'b1; scl_wdata = 8'd3;
        @(negedge clk);
        scl_wr = 1'b0;
        chk("R9 scale old tick", int'(count), 8);
        @(negedge clk);
        chk("R9 scale last old tick", int'(count), 7);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 scale new wait", int'(count), 7);
        end
        @(negedge clk);
        chk("R9 scale new tick", int'(count), 6);

        // R7: write restarts the interval with scale 3
        repeat (2) @(negedge clk);
        wr_count(20);
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            chk("R7 wait after write", int'(count), 20);
        end
        @(negedge clk);
        chk("R7 first decrement", int'(count), 19);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule